// File: doc/BRIEF.md
# Converter Serial Result Transmitter (Master Clocking)

This block handles the serial readout of an analog-to-digital converter. The analog conversion is modelled as a busy window of fixed length. A start pulse opens the window, and the result word is sampled as the window closes. When serial output is selected and the block is set to clock the link itself, it sends a 16-bit word on one data line. It divides the system clock down to make its own serial clock and raises a strobe that frames the valid data.

Two read timings are available. In the first, the new result is shifted out as soon as its conversion ends. In the second, the last completed result is shifted out while the next conversion is still running. The serial clock and the strobe each have their own polarity-inversion input. Between frames the link sits quiet.

Top module: `adc_serial_master`

## Requirements
- R1: A frame is produced only when `ser_sel` is 1 and `clk_ext_sel` is 0. With either select in the other state, the strobe stays inactive, the clock stays at its idle level and the data line stays low.
- R2: `busy` goes high in the cycle after a start pulse is accepted and stays high for exactly CONV_CYCLES cycles. A start pulse that arrives while `busy` is high has no effect on when `busy` falls.
- R3: A frame carries the DATA_W-bit word with the most significant bit first. Each bit is taken on the active (logical rising) serial clock edge.
- R4: Each frame contains exactly DATA_W active serial clock edges. Each clock half-period lasts SCLK_HALF system cycles.
- R5: The strobe is active for 2·SCLK_HALF·DATA_W consecutive cycles, and the first bit is already on the data line when the strobe becomes active.
- R6: With `sclk_inv` = 1 the serial clock pin is the logical clock inverted. With `sync_inv` = 1 the strobe pin is active-low. Otherwise both pins are active-high.
- R7: The data line changes only together with the clock's move to its idle level, or at the start of a frame. It is therefore stable through the whole active half of each clock period.
- R8: With `read_mode` = 0, the frame starts at the same clock edge at which `busy` falls and carries the result of that conversion.
- R9: With `read_mode` = 1, the frame starts at the same clock edge at which `busy` rises and carries the most recently completed result. If no conversion has completed since reset, no frame is sent.
- R10: Outside a frame the clock sits at its idle level, the strobe is inactive and the data line is low.
- R11: A frame trigger that comes while a frame is still shifting is dropped. The running frame finishes unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | One-cycle conversion start pulse |
| conv_result | input | 16 | Result word, sampled as the busy window closes |
| ser_sel | input | 1 | 1 selects serial output |
| clk_ext_sel | input | 1 | 0 makes this block the clock source |
| read_mode | input | 1 | 0: read after conversion, 1: read during the next conversion |
| sclk_inv | input | 1 | Inverts the serial clock pin |
| sync_inv | input | 1 | Inverts the strobe pin |
| busy | output | 1 | Conversion in progress |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame-valid strobe |

## Verification
Each read mode is tried with all four polarity combinations and with all-zero, all-one, alternating and end-bit words, plus a walking single one. This exposes bit-order, bit-drop and polarity faults. Running read-during-next first after reset and then chaining conversions checks whether the previous word or the new one goes out. Frame-start cycles are measured against the busy edges, which tells the two read timings apart. Extra start pulses inside a busy window and a conversion started during a running frame show whether ignored or dropped triggers leak through. Runs with either select off must stay completely silent.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef enum logic {
        RD_AFTER_CONV  = 1'b0,
        RD_DURING_NEXT = 1'b1
    } rd_mode_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_ser_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic accept_o,
    output logic done_o
);
    localparam int unsigned CW = cnt_width(CONV_CYCLES);
    localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = start_i && !st_q.busy;
        done_o   = st_q.busy && (st_q.cnt == '0);
        if (accept_o) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
        end else if (done_o) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !st_q.busy |=> st_q.busy && st_q.cnt == CNT_LOAD); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && st_q.busy && st_q.cnt != '0 |=> st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1); // R2

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_ser_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  rd_mode_e          rd_mode_i,
    input  logic              accept_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              shifting_i,
    output logic              load_o,
    output logic [DATA_W-1:0] word_o
);
    typedef struct packed {
        logic              have;
        logic [DATA_W-1:0] held;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            st_d.have = 1'b1;
            st_d.held = result_i;
        end
        load_o = 1'b0;
        word_o = result_i;
        if (enable_i && !shifting_i) begin
            if (rd_mode_i == RD_AFTER_CONV) begin
                load_o = done_i;
            end else begin
                load_o = accept_i && st_q.have;
                word_o = st_q.held;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PREV_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
        load_o && rd_mode_i == RD_DURING_NEXT |-> st_q.have && accept_i); // R9
    AST_FRESH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o && rd_mode_i == RD_AFTER_CONV |-> done_i && word_o == result_i); // R8
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        shifting_i |-> !load_o); // R11

endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter
    import adc_ser_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              shifting_o,
    output logic              sclk_o,
    output logic              sync_o,
    output logic              sdata_o
);
    localparam int unsigned HW = cnt_width(SCLK_HALF);
    localparam int unsigned BW = cnt_width(DATA_W);
    localparam int unsigned FRAME_LEN = 2 * SCLK_HALF * DATA_W;
    localparam int unsigned LW = cnt_width(FRAME_LEN + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(SCLK_HALF - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

    typedef struct packed {
        logic              sync;
        logic              sclk;
        logic              sdata;
        logic [HW-1:0]     half;
        logic [BW-1:0]     bitn;
        logic [DATA_W-1:0] sreg;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.sync) begin
            if (load_i) begin
                st_d.sync  = 1'b1;
                st_d.sclk  = 1'b0;
                st_d.half  = '0;
                st_d.bitn  = '0;
                st_d.sreg  = word_i;
                st_d.sdata = word_i[DATA_W-1];
            end
        end else if (st_q.half == HALF_LAST) begin
            st_d.half = '0;
            if (!st_q.sclk) begin
                st_d.sclk = 1'b1;
            end else begin
                st_d.sclk = 1'b0;
                if (st_q.bitn == BIT_LAST) begin
                    st_d.sync  = 1'b0;
                    st_d.sdata = 1'b0;
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.sdata = st_q.sreg[DATA_W-2];
                    st_d.sreg  = {st_q.sreg[DATA_W-2:0], 1'b0};
                end
            end
        end else begin
            st_d.half = st_q.half + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shifting_o = st_q.sync;
    assign sclk_o     = st_q.sclk;
    assign sync_o     = st_q.sync;
    assign sdata_o    = st_q.sdata;

    // checking counters: active edges and strobe length within a frame
    logic [BW:0]   rise_cnt_q;
    logic [LW-1:0] len_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt_q <= '0;
            len_cnt_q  <= '0;
        end else begin
            if (st_d.sync && !st_q.sync) begin
                rise_cnt_q <= '0;
                len_cnt_q  <= LW'(1);
            end else begin
                if (st_d.sclk && !st_q.sclk) rise_cnt_q <= rise_cnt_q + 1'b1;
                if (st_d.sync) len_cnt_q <= len_cnt_q + 1'b1;
            end
        end
    end

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sclk && $past(st_q.sclk) |-> $stable(st_q.sdata)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.sync |-> !st_q.sclk && !st_q.sdata); // R10
    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sync) |-> rise_cnt_q == (BW+1)'(DATA_W)); // R4
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sync) |-> len_cnt_q == LW'(FRAME_LEN)); // R5

endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master
    import adc_ser_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SCLK_HALF   = 2,
    parameter int unsigned CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              ser_sel,
    input  logic              clk_ext_sel,
    input  logic              read_mode,
    input  logic              sclk_inv,
    input  logic              sync_inv,
    output logic              busy,
    output logic              sclk,
    output logic              sdata,
    output logic              sync
);
    logic              accept, done, load, shifting;
    logic              sclk_raw, sync_raw, sdata_raw;
    logic [DATA_W-1:0] load_word;
    logic              master_en;
    rd_mode_e          mode;

    assign master_en = ser_sel && !clk_ext_sel;
    assign mode      = rd_mode_e'(read_mode);

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (conv_start),
        .busy_o   (busy),
        .accept_o (accept),
        .done_o   (done)
    );

    adc_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (master_en),
        .rd_mode_i  (mode),
        .accept_i   (accept),
        .done_i     (done),
        .result_i   (conv_result),
        .shifting_i (shifting),
        .load_o     (load),
        .word_o     (load_word)
    );

    adc_bit_shifter #(.DATA_W(DATA_W), .SCLK_HALF(SCLK_HALF)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .word_i     (load_word),
        .shifting_o (shifting),
        .sclk_o     (sclk_raw),
        .sync_o     (sync_raw),
        .sdata_o    (sdata_raw)
    );

    assign sclk  = sclk_raw ^ sclk_inv;
    assign sync  = sync_raw ^ sync_inv;
    assign sdata = sdata_raw;

    AST_SERIAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_raw && !master_en |=> !sync_raw); // R1
    AST_AFTER_CONV_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_raw) && !read_mode |-> $fell(busy)); // R8

endmodule

// File: tb/tb_adc_serial_master.sv
module tb_adc_serial_master;
    localparam int W    = 16;
    localparam int HALF = 2;
    localparam int CONV = 40;
    localparam int FLEN = 2 * HALF * W;
    localparam int WIN  = CONV + FLEN + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic [W-1:0] conv_result = '0;
    logic ser_sel = 1'b1, clk_ext_sel = 1'b0, read_mode = 1'b0;
    logic sclk_inv = 1'b0, sync_inv = 1'b0;
    logic busy, sclk, sdata, sync;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    bit prev_ok = 1'b0;
    logic [W-1:0] prev_word = '0;

    always #10 clk = ~clk; // 50 MHz

    adc_serial_master #(.DATA_W(W), .SCLK_HALF(HALF), .CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_result(conv_result),
        .ser_sel(ser_sel), .clk_ext_sel(clk_ext_sel), .read_mode(read_mode),
        .sclk_inv(sclk_inv), .sync_inv(sync_inv),
        .busy(busy), .sclk(sclk), .sdata(sdata), .sync(sync));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // Pulse a start, observe WIN cycles, check against expectations.
    task automatic run_conv(input logic [W-1:0] val, input bit exp_frame,
                            input logic [W-1:0] exp_word, input int exp_first,
                            input int extra_at, input int exp_busy);
        int first = -1, slen = 0, pulses = 0, unstable = 0, idle_bad = 0, blen = 0;
        logic [W-1:0] got = '0;
        logic lastbit = 1'b0, prev_c = 1'b0;
        conv_result = val;
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk) conv_start = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            logic s, c;
            s = sync ^ sync_inv;
            c = sclk ^ sclk_inv;
            if (busy) blen++;
            if (s) begin
                if (first < 0) first = i;
                slen++;
                if (c && !prev_c) begin
                    pulses++;
                    got = {got[W-2:0], sdata};
                    lastbit = sdata;
                end else if (c && sdata !== lastbit) begin
                    unstable++;
                end
            end else if (c || sdata) begin
                idle_bad++;
            end
            prev_c = c;
            if (i == extra_at) conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
        end
        chk(blen == exp_busy, "R2", "busy cycles", blen, exp_busy);
        chk(idle_bad == 0, "R10 R6", "idle level violations", idle_bad, 0);
        if (exp_frame) begin
            chk(first == exp_first, read_mode ? "R9" : "R8", "frame start cycle", first, exp_first);
            chk(got == exp_word, "R3 R6", "frame word", int'(got), int'(exp_word));
            chk(pulses == W, "R4", "active clock edges", pulses, W);
            chk(slen == FLEN, "R5 R11", "strobe length", slen, FLEN);
            chk(unstable == 0, "R7", "data changes in active half", unstable, 0);
        end else begin
            chk(first == -1, "R1 R9", "unexpected frame start", first, -1);
        end
        prev_word = val;
        prev_ok = 1'b1;
    endtask

    function automatic logic [W-1:0] pattern(input int k, input int salt);
        case (k)
            0: return '0;
            1: return '1;
            2: return 16'hA5A5 ^ W'(salt);
            3: return 16'h8001;
            default: return W'(1) << (salt % W);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R2", "reset busy", busy, 0);
        chk(sync == 1'b0, "R10", "reset strobe", sync, 0);
        chk(sclk == 1'b0, "R10", "reset clock", sclk, 0);
        chk(sdata == 1'b0, "R10", "reset data", sdata, 0);

        // R9: read-during-next with nothing completed yet gives no frame
        read_mode = 1'b1;
        run_conv(16'h1234, 1'b0, '0, -1, -1, CONV);

        // main sweep: mode x polarity x pattern
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [W-1:0] v, e;
                    read_mode = m[0];
                    sclk_inv  = p[0];
                    sync_inv  = p[1];
                    v = pattern(k, m * 8 + p * 2 + k);
                    e = m[0] ? prev_word : v;
                    run_conv(v, 1'b1, e, m[0] ? 0 : CONV, -1, CONV);
                end
            end
        end

        // R2: extra start pulse while busy is ignored
        read_mode = 1'b0; sclk_inv = 1'b0; sync_inv = 1'b0;
        run_conv(16'h3C5A, 1'b1, 16'h3C5A, CONV, 10, CONV);

        // R11: new conversion ends while the frame is still shifting
        run_conv(16'h6E01, 1'b1, 16'h6E01, CONV, CONV + 1, 2 * CONV);

        // R1: serial deselected, and external clocking selected
        ser_sel = 1'b0;
        run_conv(16'hFFFF, 1'b0, '0, -1, -1, CONV);
        read_mode = 1'b1;
        run_conv(16'hFFFF, 1'b0, '0, -1, -1, CONV);
        ser_sel = 1'b1; clk_ext_sel = 1'b1;
        run_conv(16'h5555, 1'b0, '0, -1, -1, CONV);
        read_mode = 1'b0;
        run_conv(16'h5555, 1'b0, '0, -1, -1, CONV);

        // back to master mode: read-during-next sends the last value
        clk_ext_sel = 1'b0; read_mode = 1'b1;
        run_conv(16'h0F0F, 1'b1, 16'h5555, 0, -1, CONV);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule